// File: doc/BRIEF.md
# Dual-Channel Timer Output Compare

This block is the output-compare section that sits beside a 16-bit free-running timer. It has two independent channels. Each keeps a 16-bit compare value that software loads one byte at a time. When the timer count reaches a channel's match point, the channel raises its flag and loads its programmed output level into a pin latch. A forced-output strobe can load the level without a match, and a single interrupt request combines both flags.

The match point depends on the prescaler selection. For the two faster settings a channel matches while the count equals its compare value. For the slowest setting and for external clocking it matches one count later. Loading the upper byte of a compare value disarms the channel, and loading the lower byte arms it again. This lets software change a 16-bit value without a stray match on a half-written value.

All inputs are plain register-side strobes and levels. Register writes are always accepted in the cycle they are presented, so there is no back-pressure. The count is sampled on every clock. The timer itself, input capture and the one-pulse and PWM engines are outside the block. Only their mode-select inputs enter it, and they decide whether force strobes take effect.

Top module: `dual_ocmp`

## Requirements
- R1: After reset both channels are disarmed, both flags, both pin latches and the interrupt are 0, and the compare values are 0xFFFF. A count of 0xFFFF therefore sets no flag until a compare byte is written.
- R2: With `presc_i` = 0 (divide by 4) or 1 (divide by 2), an armed channel whose compare value equals `cnt_i` at a clock edge shows its flag set after that edge and loads its pin latch with its `lvl_i` bit.
- R3: With `presc_i` = 2 (divide by 8) or 3 (external clock), the match occurs when `cnt_i` equals the compare value plus one, with 16-bit wrap. A count equal to the compare value itself does not match.
- R4: Writes use `wr_addr_i`, where bit 1 selects the channel and bit 0 selects the byte (0 = upper, 1 = lower). A write to the upper byte disarms that channel. The channel stays disarmed until its lower byte is written.
- R5: While a channel's `oen_i` bit is 0, its `ocmp_oe_o` bit and its `ocmp_o` bit are 0. A match still sets the flag.
- R6: A pulse on a channel's `frc_i` bit loads its `lvl_i` bit into the pin latch on the next edge. It does not set the flag.
- R7: While `opm_i` or `pwm_i` is 1, force pulses have no effect on the pin latch.
- R8: Matches set flags and load latches in the same way when `opm_i` or `pwm_i` is 1.
- R9: A flag is cleared only when `sts_rd_i` is pulsed while the flag is set and is then followed by a lower-byte write to that channel. A lower-byte write without the preceding status read leaves the flag set. A match in the same cycle wins over a clear.
- R10: `irq_o` is 1 exactly when `ie_i` is 1 and at least one flag is set.
- R11: A pin latch holds its value between matches and force pulses, even when `lvl_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Current timer count |
| presc_i | input | 2 | Prescaler selection: 0 = /4, 1 = /2, 2 = /8, 3 = external |
| opm_i | input | 1 | One-pulse mode selected |
| pwm_i | input | 1 | PWM mode selected |
| wr_en_i | input | 1 | Compare byte write strobe |
| wr_addr_i | input | 2 | Bit 1 = channel, bit 0 = byte (0 upper, 1 lower) |
| wr_data_i | input | 8 | Byte written |
| sts_rd_i | input | 1 | Status register read strobe |
| lvl_i | input | 2 | Output level per channel |
| oen_i | input | 2 | Pin output enable per channel |
| frc_i | input | 2 | Force strobe per channel |
| ie_i | input | 1 | Interrupt enable |
| flag_o | output | 2 | Channel flags (status) |
| ocmp_o | output | 2 | Compare pin levels |
| ocmp_oe_o | output | 2 | Compare pin drive enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The match is tried with counts one below the compare value, equal to it and one above it, under both fast and slow prescaler groups. This separates the offset-by-one rule from a plain equality. A half-written compare value is presented with the count at the new value, to tell a disarmed channel from an armed one. Force pulses are sent in normal mode and in PWM mode, and matches are repeated in PWM mode, to separate the force lock from the match path. Lower-byte writes are issued with and without a prior status read, to show that the clear needs both steps.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic [1:0] {
    PS_DIV4 = 2'd0,
    PS_DIV2 = 2'd1,
    PS_DIV8 = 2'd2,
    PS_EXT  = 2'd3
  } presc_e;

  // slow settings match one count after the compare value
  function automatic logic late_match(input logic [1:0] sel);
    return (sel == PS_DIV8) || (sel == PS_EXT);
  endfunction
endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         late,
  input  logic         armed,
  output logic         hit
);
  logic [W-1:0] target;

  always_comb begin
    target = cmp + W'(late);
    hit    = armed && (cnt == target);
  end

  // R3: in the late group the raw compare value itself never matches
  a_r3_late_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (late && cnt == cmp) |-> !hit);
endmodule

// File: rtl/ocmp_chan.sv
module ocmp_chan #(
  parameter int BYTE_W = 8,
  localparam int W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] data,
  input  logic [W-1:0]      cnt,
  input  logic              late,
  input  logic              lvl,
  input  logic              frc,
  input  logic              lock,
  input  logic              sts_rd,
  output logic              flag,
  output logic              latch
);
  logic [W-1:0] cmp;
  logic         armed;
  logic         clr_pend;
  logic         hit;

  ocmp_match #(.W(W)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt),
    .cmp   (cmp),
    .late  (late),
    .armed (armed),
    .hit   (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp      <= '1;
      armed    <= 1'b0;
      flag     <= 1'b0;
      latch    <= 1'b0;
      clr_pend <= 1'b0;
    end else begin
      if (wr_hi) begin
        cmp[W-1:BYTE_W] <= data;
        armed           <= 1'b0;
      end
      if (wr_lo) begin
        cmp[BYTE_W-1:0] <= data;
        armed           <= 1'b1;
      end
      if (sts_rd && flag) clr_pend <= 1'b1;
      if (wr_lo && clr_pend) begin
        flag     <= 1'b0;
        clr_pend <= 1'b0;
      end
      // match last so it wins over a clear in the same cycle
      if (hit) begin
        flag  <= 1'b1;
        latch <= lvl;
      end else if (frc && !lock) begin
        latch <= lvl;
      end
    end
  end

  a_r2_match_loads: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (flag && latch == $past(lvl)));
  a_r4_hi_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> !armed);
  a_r6_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !hit) |=> !flag);
  a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !hit) |=> $stable(latch));
  a_r9_needs_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_lo) |=> flag);
endmodule

// File: rtl/dual_ocmp.sv
module dual_ocmp #(
  parameter int NCH    = 2,
  parameter int BYTE_W = 8,
  localparam int W   = 2 * BYTE_W,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      cnt_i,
  input  logic [1:0]        presc_i,
  input  logic              opm_i,
  input  logic              pwm_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              sts_rd_i,
  input  logic [NCH-1:0]    lvl_i,
  input  logic [NCH-1:0]    oen_i,
  input  logic [NCH-1:0]    frc_i,
  input  logic              ie_i,
  output logic [NCH-1:0]    flag_o,
  output logic [NCH-1:0]    ocmp_o,
  output logic [NCH-1:0]    ocmp_oe_o,
  output logic              irq_o
);
  import ocmp_pkg::*;

  logic           late;
  logic           lock;
  logic [NCH-1:0] latch;

  assign late = late_match(presc_i);
  assign lock = opm_i | pwm_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && (wr_addr_i[AW-1:1] == CHW'(g));

    ocmp_chan #(.BYTE_W(BYTE_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hi  (sel && !wr_addr_i[0]),
      .wr_lo  (sel && wr_addr_i[0]),
      .data   (wr_data_i),
      .cnt    (cnt_i),
      .late   (late),
      .lvl    (lvl_i[g]),
      .frc    (frc_i[g]),
      .lock   (lock),
      .sts_rd (sts_rd_i),
      .flag   (flag_o[g]),
      .latch  (latch[g])
    );

    assign ocmp_o[g]    = oen_i[g] & latch[g];
    assign ocmp_oe_o[g] = oen_i[g];

    a_r5_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
      !oen_i[g] |-> (!ocmp_o[g] && !ocmp_oe_o[g]));
  end

  assign irq_o = ie_i & (|flag_o);

  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o |-> ie_i) and (!irq_o |-> (!ie_i || flag_o == '0)));
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (flag_o == '0 && !irq_o));
endmodule

// File: tb/dual_ocmp_tb.sv
module dual_ocmp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = '0;
  logic [1:0]  presc_i = 2'd0;
  logic        opm_i = 1'b0, pwm_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        sts_rd_i = 1'b0;
  logic [1:0]  lvl_i = '0, oen_i = '0, frc_i = '0;
  logic        ie_i = 1'b0;
  logic [1:0]  flag_o, ocmp_o, ocmp_oe_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dual_ocmp u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .presc_i(presc_i),
    .opm_i(opm_i), .pwm_i(pwm_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .sts_rd_i(sts_rd_i), .lvl_i(lvl_i), .oen_i(oen_i),
    .frc_i(frc_i), .ie_i(ie_i), .flag_o(flag_o), .ocmp_o(ocmp_o),
    .ocmp_oe_o(ocmp_oe_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic sts_read();
    @(negedge clk); sts_rd_i = 1'b1;
    @(negedge clk); sts_rd_i = 1'b0;
  endtask

  // present a count for one edge, then park at 0
  task automatic count(input logic [15:0] c);
    @(negedge clk); cnt_i = c;
    @(negedge clk); cnt_i = 16'h0000;
  endtask

  task automatic pulse_frc(input logic [1:0] f);
    @(negedge clk); frc_i = f;
    @(negedge clk); frc_i = 2'b00;
  endtask

  task automatic t_reset();
    chk("R1 flags", {14'd0, flag_o}, 16'd0);
    chk("R1 pins", {14'd0, ocmp_o}, 16'd0);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    count(16'hFFFF);
    chk("R1 disarmed at FFFF", {14'd0, flag_o}, 16'd0);
  endtask

  task automatic t_fast_match();
    presc_i = 2'd0; oen_i = 2'b11; lvl_i = 2'b01;
    wr(2'b00, 8'h12); wr(2'b01, 8'h34);
    count(16'h1233);
    chk("R2 below", {14'd0, flag_o}, 16'd0);
    count(16'h1234);
    chk("R2 equal flag", {14'd0, flag_o}, 16'd1);
    chk("R2 pin level", {14'd0, ocmp_o}, 16'd1);
    @(negedge clk); lvl_i = 2'b00;
    @(negedge clk);
    chk("R11 latch holds", {14'd0, ocmp_o}, 16'd1);
  endtask

  task automatic t_slow_match();
    presc_i = 2'd2; lvl_i = 2'b10;
    wr(2'b10, 8'h00); wr(2'b11, 8'h50);
    count(16'h0050);
    chk("R3 raw value no match", {14'd0, flag_o}, 16'd1);
    count(16'h0051);
    chk("R3 plus one match", {14'd0, flag_o}, 16'd3);
    chk("R3 pin", {14'd0, ocmp_o}, 16'd3);
  endtask

  task automatic t_irq();
    ie_i = 1'b0; @(negedge clk);
    chk("R10 gated off", {15'd0, irq_o}, 16'd0);
    ie_i = 1'b1; @(negedge clk);
    chk("R10 on", {15'd0, irq_o}, 16'd1);
  endtask

  task automatic t_clear();
    wr(2'b11, 8'h50);
    chk("R9 no read no clear", {14'd0, flag_o}, 16'd3);
    sts_read();
    wr(2'b01, 8'h34);
    chk("R9 ch0 cleared", {14'd0, flag_o}, 16'd2);
    wr(2'b11, 8'h50);
    chk("R9 ch1 cleared", {14'd0, flag_o}, 16'd0);
    chk("R10 off with no flag", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_inhibit();
    presc_i = 2'd0; oen_i = 2'b10; lvl_i = 2'b01;
    wr(2'b00, 8'h20);
    count(16'h2034);
    chk("R4 disarmed after upper", {14'd0, flag_o}, 16'd0);
    wr(2'b01, 8'h34);
    count(16'h2034);
    chk("R4 rearmed flag", {14'd0, flag_o}, 16'd1);
    chk("R5 pin released", {14'd0, ocmp_o & 2'b01}, 16'd0);
    chk("R5 oe low", {14'd0, ocmp_oe_o & 2'b01}, 16'd0);
    oen_i = 2'b11; @(negedge clk);
    chk("R5 latch kept level", {14'd0, ocmp_o & 2'b01}, 16'd1);
  endtask

  task automatic t_force();
    lvl_i = 2'b01;
    pulse_frc(2'b10);
    chk("R6 force low", {14'd0, ocmp_o & 2'b10}, 16'd0);
    chk("R6 no flag", {14'd0, flag_o & 2'b10}, 16'd0);
    pwm_i = 1'b1; lvl_i = 2'b11;
    pulse_frc(2'b10);
    chk("R7 force locked", {14'd0, ocmp_o & 2'b10}, 16'd0);
    presc_i = 2'd3;
    count(16'h0051);
    chk("R8 match in pwm", {14'd0, flag_o & 2'b10}, 16'd2);
    chk("R8 pin in pwm", {14'd0, ocmp_o & 2'b10}, 16'd2);
    pwm_i = 1'b0;
  endtask

  task automatic t_div2();
    sts_read(); wr(2'b11, 8'h50);
    chk("R9 ch1 clear again", {14'd0, flag_o & 2'b10}, 16'd0);
    presc_i = 2'd1;
    count(16'h0051);
    chk("R2 div2 above no match", {14'd0, flag_o & 2'b10}, 16'd0);
    count(16'h0050);
    chk("R2 div2 equal match", {14'd0, flag_o & 2'b10}, 16'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast_match();
    t_slow_match();
    t_irq();
    t_clear();
    t_inhibit();
    t_force();
    t_div2();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule